// File: doc/BRIEF.md
# Reachable State-Space Explorer with Deduplication

This block enumerates, on chip, the reachable boundary states of a small guard-driven state machine, here a relay controller. The states it keeps are the one just before a ringlet samples its inputs (a Read state) and the one just after the ringlet publishes its outputs (a Write state). It keeps a FIFO work queue of unexplored Read states. Each Read state holds the machine state, a flag that says whether the entry action runs, and the current relay output.

For every dequeued Read state the block starts one ringlet engine copy per input combination and waits until every copy has finished. All copies are always started, but only the combinations that vary the inputs the state actually reads are used. The block then walks the copies in a fixed order. For each distinct Write result it emits one edge record, and any Write result never seen before goes into a fully associative visited table and onto the queue. Exploration ends with a done pulse once the queue runs dry, or aborts with an overflow flag when the visited table cannot take a new state.

The relay machine reads two inputs: a 2-bit demand code and a 1-bit heat flag. It drives one relay output. Records leave through a valid/ready stream, so a consumer such as a serial link can pace the walk.

Top module: `kx_explorer`

## Requirements
- R1: After reset `rec_valid`, `done` and `overflow` are 0.
- R2: A state is packed 4 bits wide as {state[3:2], entry[1], relay[0]}, with state codes INIT=0, OFF=1, ON=2. A record is {Read[7:4], Write[3:0]}. Exploration starts from Read {INIT,1,0}, whose first record is 8'h26.
- R3: Engines are indexed by the combination {demand[2:1], heat[0]}. INIT reads no inputs, so only combination 0 counts, and its Write is {OFF,1,0}. On entry, OFF clears relay and ON sets it. OFF moves to ON only when demand is 2 and heat is 1. ON moves to OFF when demand is 1. A Write holds the next state, entry=1 if and only if a transition fired, and the relay value.
- R4: Within one Read state, identical Write results produce a single record, placed at the lowest combination index that yields that result.
- R5: A Write state already in the visited table is not enqueued again, so each Read state runs once. With the default table the walk emits exactly 11 records.
- R6: The queue is first-in first-out. Records come grouped by Read state in the order 2, 6, 4, A, 9, 7.
- R7: `done` pulses for one cycle after the last record. A later `start` repeats the same sequence.
- R8: When a new state meets a full visited table, `overflow` rises, `done` pulses and no further record appears. `overflow` stays 1 until the next `start`.
- R9: While `rec_valid` is high and `rec_ready` is low, `rec_valid` and `rec_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin exploration (accepted when idle) |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Edge record available |
| rec_data | output | 8 | {Read state, Write state} |
| done | output | 1 | One-cycle end-of-walk pulse |
| overflow | output | 1 | Visited table overflowed; walk aborted |

## Verification
The assertions assume that `rec_ready` is the only input that changes while a walk is running, and that `start` arrives only while the block is idle. The bench therefore raises `start` only after the previous `done` pulse and changes `rec_ready` on its own schedule. Internally, the assertions rely on the queue never being pushed beyond the visited capacity. They also rely on every insertion being a state that missed in the visited table, and on no engine being restarted before it finishes. A second instance with a four-entry table drives the abort path.

// File: rtl/kx_pkg.sv
package kx_pkg;
  localparam int KX_IN_W = 3;

  typedef enum logic [1:0] {MS_INIT = 2'd0, MS_OFF = 2'd1, MS_ON = 2'd2} mstate_e;

  typedef struct packed {
    mstate_e st;
    logic    entry;
    logic    relay;
  } kstate_t;

  localparam kstate_t KX_SEED = '{st: MS_INIT, entry: 1'b1, relay: 1'b0};

  // inputs a state samples: INIT none, others demand and heat
  function automatic logic [KX_IN_W-1:0] used_mask(input mstate_e s);
    return (s == MS_INIT) ? '0 : '1;
  endfunction

  function automatic logic entry_relay(input mstate_e s, input logic r);
    case (s)
      MS_OFF:  return 1'b0;
      MS_ON:   return 1'b1;
      default: return r;
    endcase
  endfunction

  function automatic logic fires(input mstate_e s, input logic [KX_IN_W-1:0] in);
    case (s)
      MS_INIT: return 1'b1;
      MS_OFF:  return (in[2:1] == 2'b10) && in[0];
      MS_ON:   return (in[2:1] == 2'b01);
      default: return 1'b0;
    endcase
  endfunction

  function automatic mstate_e target(input mstate_e s);
    case (s)
      MS_INIT: return MS_OFF;
      MS_OFF:  return MS_ON;
      MS_ON:   return MS_OFF;
      default: return MS_INIT;
    endcase
  endfunction
endpackage

// File: rtl/kx_ringlet.sv
module kx_ringlet
  import kx_pkg::*;
#(
  parameter int unsigned COMBO = 0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    go,
  input  kstate_t rd_i,
  output kstate_t wr_o,
  output logic    fin_o
);
  localparam logic [KX_IN_W-1:0] IN_VAL = KX_IN_W'(COMBO);

  typedef enum logic [2:0] {PH_IDLE, PH_ENTRY, PH_CHECK, PH_ACT, PH_WRITE, PH_DONE} phase_e;
  phase_e  ph;
  mstate_e st_q;
  mstate_e tgt_q;
  logic    entry_q, relay_q, fired_q;
  kstate_t wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; st_q <= MS_INIT; tgt_q <= MS_INIT;
      entry_q <= 1'b0; relay_q <= 1'b0; fired_q <= 1'b0; wr_q <= KX_SEED;
    end else begin
      case (ph)
        PH_ENTRY: begin
          if (entry_q) relay_q <= entry_relay(st_q, relay_q);
          ph <= PH_CHECK;
        end
        PH_CHECK: begin
          fired_q <= fires(st_q, IN_VAL);
          tgt_q   <= target(st_q);
          ph <= PH_ACT;
        end
        PH_ACT:   ph <= PH_WRITE;  // exit and internal actions are empty
        PH_WRITE: begin
          wr_q <= '{st: fired_q ? tgt_q : st_q, entry: fired_q, relay: relay_q};
          ph <= PH_DONE;
        end
        default: ;
      endcase
      if (go) begin  // read snapshot
        st_q <= rd_i.st; entry_q <= rd_i.entry; relay_q <= rd_i.relay;
        ph <= PH_ENTRY;
      end
    end
  end

  assign wr_o  = wr_q;
  assign fin_o = (ph == PH_DONE);

  // R3
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> (ph == PH_IDLE || ph == PH_DONE));
  // R3
  go_clear_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> !fin_o);
endmodule

// File: rtl/kx_fifo.sv
module kx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
    if (pop)  dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/kx_visit.sv
module kx_visit
  import kx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    ins,
  input  kstate_t key,
  output logic    hit,
  output logic    full
);
  localparam int CW = $clog2(DEPTH + 1);

  kstate_t       keys [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] hit_vec;
  logic [CW-1:0]    cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (keys[i] == key);
    always_ff @(posedge clk) begin
      if (rst || clr) vld[i] <= 1'b0;
      else if (ins && cnt == CW'(i)) vld[i] <= 1'b1;
      if (ins && cnt == CW'(i)) keys[i] <= key;
    end
  end

  assign hit  = |hit_vec;
  assign full = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (ins)   cnt <= cnt + 1'b1;
  end

  // R5
  ins_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    ins |-> (!hit && !full));
  // R5
  one_match_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_vec) <= 1);
endmodule

// File: rtl/kx_explorer.sv
module kx_explorer
  import kx_pkg::*;
#(
  parameter int VIS_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                rec_ready,
  output logic                rec_valid,
  output logic [2*$bits(kstate_t)-1:0] rec_data,
  output logic                done,
  output logic                overflow
);
  localparam int KS_W     = $bits(kstate_t);
  localparam int NUM_INST = 1 << KX_IN_W;

  typedef enum logic [3:0] {S_IDLE, S_SEED, S_POP, S_LAUNCH, S_WAIT,
                            S_SCAN, S_EMIT, S_LOOK, S_FIN} fsm_e;
  fsm_e state;

  logic [KX_IN_W-1:0]  idx;
  kstate_t             cur_rd;
  kstate_t             wr_arr [NUM_INST];
  logic [NUM_INST-1:0] fin_vec, valid_vec, first_vec;
  kstate_t             q_dout, vis_key;
  logic q_empty, q_full, q_push, q_pop, vis_hit, vis_full, vis_ins, clr, last_idx;

  assign clr      = (state == S_IDLE) && start;
  assign vis_key  = (state == S_SEED) ? KX_SEED : wr_arr[idx];
  assign vis_ins  = (state == S_SEED) || (state == S_LOOK && !vis_hit && !vis_full);
  assign q_push   = vis_ins;
  assign q_pop    = (state == S_POP) && !q_empty;
  assign last_idx = (idx == KX_IN_W'(NUM_INST-1));

  kx_fifo #(.DEPTH(VIS_DEPTH), .W(KS_W)) u_queue (
    .clk(clk), .rst(rst), .clr(clr), .push(q_push), .din(vis_key),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full));

  kx_visit #(.DEPTH(VIS_DEPTH)) u_seen (
    .clk(clk), .rst(rst), .clr(clr), .ins(vis_ins), .key(vis_key),
    .hit(vis_hit), .full(vis_full));

  for (genvar i = 0; i < NUM_INST; i++) begin : g_eng
    kx_ringlet #(.COMBO(i)) u_eng (
      .clk(clk), .rst(rst), .go(state == S_LAUNCH), .rd_i(q_dout),
      .wr_o(wr_arr[i]), .fin_o(fin_vec[i]));
    assign valid_vec[i] = ((KX_IN_W'(i) & ~used_mask(cur_rd.st)) == '0);
    always_comb begin
      first_vec[i] = 1'b1;
      for (int j = 0; j < i; j++)
        if (valid_vec[j] && wr_arr[j] == wr_arr[i]) first_vec[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; idx <= '0; cur_rd <= KX_SEED;
      rec_valid <= 1'b0; rec_data <= '0; done <= 1'b0; overflow <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin overflow <= 1'b0; state <= S_SEED; end
        S_SEED: state <= S_POP;
        S_POP:  state <= q_empty ? S_FIN : S_LAUNCH;
        S_LAUNCH: begin cur_rd <= q_dout; state <= S_WAIT; end
        S_WAIT: if (&fin_vec) begin idx <= '0; state <= S_SCAN; end
        S_SCAN: begin
          if (valid_vec[idx] && first_vec[idx]) begin
            rec_valid <= 1'b1;
            rec_data  <= {cur_rd, wr_arr[idx]};
            state     <= S_EMIT;
          end else if (last_idx) state <= S_POP;
          else begin idx <= idx + 1'b1; state <= S_SCAN; end
        end
        S_EMIT: if (rec_ready) begin rec_valid <= 1'b0; state <= S_LOOK; end
        S_LOOK: begin
          if (!vis_hit && vis_full) begin
            overflow <= 1'b1; state <= S_FIN;
          end else if (last_idx) state <= S_POP;
          else begin idx <= idx + 1'b1; state <= S_SCAN; end
        end
        S_FIN: begin done <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rec_valid);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !start) |=> overflow);
  // R8
  ovf_silent_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !rec_valid);
endmodule

// File: tb/sim_kx_explorer.sv
module sim_kx_explorer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start0 = 1'b0, start1 = 1'b0;
  logic rdy0 = 1'b0, rdy1 = 1'b1;
  logic rv0, rv1, done0, done1, ovf0, ovf1;
  logic [7:0] rd0, rd1;

  int checks = 0, fails = 0, cyc = 0, nrec0 = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got1[$];
  logic       stall_q = 1'b0;
  logic [7:0] stall_d = '0;

  always #5 clk = ~clk;

  kx_explorer u0 (.clk(clk), .rst(rst), .start(start0), .rec_ready(rdy0),
    .rec_valid(rv0), .rec_data(rd0), .done(done0), .overflow(ovf0));
  kx_explorer #(.VIS_DEPTH(4)) u1 (.clk(clk), .rst(rst), .start(start1), .rec_ready(rdy1),
    .rec_valid(rv1), .rec_data(rd1), .done(done1), .overflow(ovf1));

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic load_walk();
    push_exp(8'h26, "R2 seed edge");
    push_exp(8'h64, "R4 OFF-entry stay");
    push_exp(8'h6A, "R3 OFF to ON at combo 5");
    push_exp(8'h44, "R5 OFF stay");
    push_exp(8'h4A, "R5 OFF to ON");
    push_exp(8'hA9, "R6 ON-entry stay");
    push_exp(8'hA7, "R3 ON to OFF at combo 2");
    push_exp(8'h99, "R6 ON stay");
    push_exp(8'h97, "R6 ON to OFF");
    push_exp(8'h74, "R6 OFF-entry relay clear");
    push_exp(8'h7A, "R6 OFF-entry to ON");
  endtask

  // backpressure driver
  initial begin
    forever begin
      @(posedge clk); #1;
      rdy0 = ((cyc % 3) != 1);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (stall_q)  // R9 hold while stalled
        check(rv0 && rd0 == stall_d, "R9 hold", int'(rd0), int'(stall_d));
      stall_q = rv0 && !rdy0;
      stall_d = rd0;
      if (rv0 && rdy0) begin
        nrec0++;
        if (exp_q.size() == 0) check(1'b0, "R5 extra record", int'(rd0), 0);
        else begin
          logic [7:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(rd0 == e, t, int'(rd0), int'(e));
        end
      end
      if (rv1 && rdy1) got1.push_back(rd1);
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic walk0(input string tag);
    nrec0 = 0;
    load_walk();
    @(negedge clk) start0 = 1'b1;
    @(negedge clk) start0 = 1'b0;
    do @(negedge clk); while (!done0);
    check(exp_q.size() == 0, {tag, " R7 all records before done"}, exp_q.size(), 0);
    check(nrec0 == 11, {tag, " R5 record count"}, nrec0, 11);
    check(!ovf0, {tag, " R8 no overflow"}, int'(ovf0), 0);
    @(negedge clk);
    check(!done0, {tag, " R7 done one cycle"}, int'(done0), 0);
  endtask

  initial begin
    logic [7:0] exp1 [6];
    exp1 = '{8'h26, 8'h64, 8'h6A, 8'h44, 8'h4A, 8'hA9};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rv0, "R1 rec_valid reset", int'(rv0), 0);
    check(!done0, "R1 done reset", int'(done0), 0);
    check(!ovf0, "R1 overflow reset", int'(ovf0), 0);

    walk0("run1");
    repeat (5) @(negedge clk);
    walk0("run2 restart");

    // small table: abort path
    @(negedge clk) start1 = 1'b1;
    @(negedge clk) start1 = 1'b0;
    do @(negedge clk); while (!done1);
    check(ovf1 == 1'b1, "R8 overflow raised", int'(ovf1), 1);
    check(got1.size() == 6, "R8 records before abort", got1.size(), 6);
    for (int k = 0; k < 6 && k < got1.size(); k++)
      check(got1[k] == exp1[k], "R8 record before abort", int'(got1[k]), int'(exp1[k]));
    repeat (20) @(negedge clk);
    check(got1.size() == 6, "R8 no record after abort", got1.size(), 6);
    check(ovf1 == 1'b1, "R8 overflow sticky", int'(ovf1), 1);
    @(negedge clk) start1 = 1'b1;
    @(negedge clk) start1 = 1'b0;
    check(ovf1 == 1'b0, "R8 overflow cleared by start", int'(ovf1), 0);
    do @(negedge clk); while (!done1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule